// File: doc/BRIEF.md
# SPI Write-Then-Read Packet Sequencer

This block runs one chip-select transaction against a word-oriented SPI master. A transaction is requested with two byte counts: how many bytes go out to the device, and how many bytes come back after them. The sequencer cuts the transaction into packets of at most four bytes. Each packet is filled with outgoing bytes first, and any free byte slots then carry incoming bytes. Because of this, the point where writing turns into reading can land inside a packet, and it moves from one transaction to the next.

For every packet the block takes outgoing bytes from a valid/ready byte stream and packs them into a transmit word. It then presents that word and the packet's bit length to the master and raises a one-cycle start. It waits for the master's completion strobe, and finally unpacks the received bytes of the packet onto a valid/ready output byte stream. Chip select stays asserted across all packets of the transaction. A one-cycle status-clear strobe marks the opening and the closing of the transaction. If the master does not complete a packet within a bounded number of cycles, the transaction is abandoned and flagged as failed.

Top module: `spi_pkt_seq`

## Requirements
- R1: A packet carries min(writes still pending, 4) outgoing bytes. Its bit length is 8 times the number of bytes it carries. No packet with zero bytes is ever started.
- R2: A packet carries min(reads still pending, 4 minus that packet's outgoing bytes) incoming bytes. A packet that carries incoming bytes is only started once every outgoing byte has been placed.
- R3: A transaction of 6 writes and 5 reads produces exactly three packets, of 32, 32 and 24 bits.
- R4: In a packet of n bytes, outgoing byte i (0 = first taken from the stream) is placed in byte lane n-1-i of `pkt_tx_word`, where lane k is bits [8k+7:8k]. Lanes that carry no outgoing byte are zero.
- R5: In a packet with r incoming bytes, incoming byte i is taken from lane r-1-i of `pkt_rx_word`. The bytes leave on `rd_data` in order. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds.
- R6: `cs_active` rises in the cycle after a transaction is accepted and is high at every `pkt_start`. It is low again in the cycle where `txn_done` pulses. `stat_clr` is high for exactly one cycle when chip select opens and for one cycle when it closes.
- R7: If `pkt_done` is absent for TIMEOUT consecutive cycles after a `pkt_start`, the transaction aborts. `txn_done` pulses with `txn_err` high, chip select is released, and no further packet starts or byte is delivered.
- R8: A `pkt_done` that arrives in the last cycle of the TIMEOUT window is accepted and takes priority over the abort.
- R9: A transaction with zero writes and zero reads starts no packet. It holds `cs_active` high for exactly one cycle and ends with `txn_done` and `txn_err` low.
- R10: `txn_start` has no effect while a transaction is in progress: the packets and the done pulse are those of the first request.
- R11: `txn_err` is cleared when the next transaction is accepted, and it only rises together with `txn_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Request a transaction (taken when idle) |
| txn_wr_cnt | input | CNT_W | Number of bytes to write |
| txn_rd_cnt | input | CNT_W | Number of bytes to read |
| txn_done | output | 1 | One-cycle end-of-transaction pulse |
| txn_err | output | 1 | Last transaction aborted on timeout |
| wr_valid | input | 1 | Outgoing byte valid |
| wr_data | input | 8 | Outgoing byte |
| wr_ready | output | 1 | Sequencer takes an outgoing byte |
| rd_valid | output | 1 | Incoming byte valid |
| rd_data | output | 8 | Incoming byte |
| rd_ready | input | 1 | Consumer takes an incoming byte |
| pkt_start | output | 1 | One-cycle strobe: master runs a packet |
| pkt_tx_word | output | 8*PKT_BYTES | Packed transmit word |
| pkt_bits | output | clog2(8*PKT_BYTES+1) | Packet length in bits |
| pkt_done | input | 1 | Master finished the packet |
| pkt_rx_word | input | 8*PKT_BYTES | Received word, valid with pkt_done |
| cs_active | output | 1 | Chip select asserted (active high) |
| stat_clr | output | 1 | One-cycle status-clear strobe |

## Verification
The packet-completion strobe and the expiry of the wait bound can fall in the same cycle. The bench provokes this by having its master model answer in exactly the TIMEOUT-th wait cycle. It judges the result by a clean finish with every incoming byte delivered. The same transaction is then repeated with the answer one cycle later, and it must abort with the error flag set. A second overlap exists between a new request and a transaction already in flight: a request is injected mid-transaction, and the packet log and the done count must match the first request only.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_FILL,
    ST_FIRE,
    ST_WAIT,
    ST_DRAIN
  } seq_st_e;

  // outgoing bytes a packet takes: all pending up to the packet capacity
  function automatic int unsigned wr_take(int unsigned left, int unsigned cap);
    return (left < cap) ? left : cap;
  endfunction

  // incoming bytes fill only the slots the outgoing bytes left free
  function automatic int unsigned rd_take(int unsigned left, int unsigned cap,
                                          int unsigned used);
    return (left < cap - used) ? left : cap - used;
  endfunction

  // byte i of a group of n sits n-1-i lanes up from lane 0
  function automatic int unsigned lane_for(int unsigned n, int unsigned idx);
    return n - 1 - idx;
  endfunction

  function automatic int unsigned bits_for(int unsigned nbytes);
    return nbytes * 8;
  endfunction

endpackage

// File: rtl/spi_seq_plan.sv
module spi_seq_plan
  import spi_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PKT_BYTES = 4,
  parameter int LANE_W    = 3
) (
  input  logic [CNT_W-1:0]  wr_left,
  input  logic [CNT_W-1:0]  rd_left,
  output logic [LANE_W-1:0] n_wr,
  output logic [LANE_W-1:0] n_rd,
  output logic              none_left
);

  always_comb begin
    n_wr      = LANE_W'(wr_take(32'(wr_left), PKT_BYTES));
    n_rd      = LANE_W'(rd_take(32'(rd_left), PKT_BYTES, 32'(n_wr)));
    none_left = (n_wr == '0) && (n_rd == '0);
  end

endmodule

// File: rtl/spi_seq_lanes.sv
module spi_seq_lanes #(
  parameter int PKT_BYTES = 4,
  parameter int LIDX_W    = 2,
  parameter int WORD_W    = 32
) (
  input  logic [WORD_W-1:0] tx_word_q,
  input  logic [7:0]        wr_byte,
  input  logic [LIDX_W-1:0] wr_lane,
  output logic [WORD_W-1:0] tx_word_nx,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [LIDX_W-1:0] rd_lane,
  output logic [7:0]        rd_byte
);

  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_lane
    assign tx_word_nx[g*8 +: 8] = (wr_lane == LIDX_W'(g)) ? wr_byte
                                                          : tx_word_q[g*8 +: 8];
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < PKT_BYTES; k++) begin
      if (rd_lane == LIDX_W'(k)) rd_byte = rx_word[k*8 +: 8];
    end
  end

endmodule

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
  parameter int LIMIT = 1000,
  parameter int TMR_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);

  logic [TMR_W-1:0] cnt;

  assign expire = run && (cnt == TMR_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart)         cnt <= '0;
    else if (run && !expire)  cnt <= cnt + TMR_W'(1);
  end

endmodule

// File: rtl/spi_pkt_seq.sv
module spi_pkt_seq
  import spi_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PKT_BYTES = 4,
  parameter int TIMEOUT   = 1000,
  localparam int WORD_W   = 8 * PKT_BYTES,
  localparam int BITS_W   = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [CNT_W-1:0]  txn_wr_cnt,
  input  logic [CNT_W-1:0]  txn_rd_cnt,
  output logic              txn_done,
  output logic              txn_err,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              rd_ready,
  output logic              pkt_start,
  output logic [WORD_W-1:0] pkt_tx_word,
  output logic [BITS_W-1:0] pkt_bits,
  input  logic              pkt_done,
  input  logic [WORD_W-1:0] pkt_rx_word,
  output logic              cs_active,
  output logic              stat_clr
);

  localparam int LANE_W = $clog2(PKT_BYTES + 1);
  localparam int LIDX_W = $clog2(PKT_BYTES);
  localparam int TMR_W  = $clog2(TIMEOUT);

  seq_st_e           st;
  logic [CNT_W-1:0]  wr_left, rd_left;
  logic [LANE_W-1:0] pkt_nw, pkt_nr, idx;
  logic [WORD_W-1:0] tx_word, rx_word, tx_word_nx;
  logic              cs_q, clr_q, done_q, err_q;

  logic [LANE_W-1:0] n_wr, n_rd;
  logic              none_left;
  logic [LIDX_W-1:0] wr_lane, rd_lane;
  logic [7:0]        rd_byte;
  logic              tmr_expire;

  // named internal events, also observed by the checker
  logic ev_accept, ev_plan_empty, ev_fire, ev_wr_take, ev_done_take;
  logic ev_abort, ev_rd_take, ev_finish, wr_last, rd_last;

  spi_seq_plan #(.CNT_W(CNT_W), .PKT_BYTES(PKT_BYTES), .LANE_W(LANE_W)) u_plan (
    .wr_left(wr_left), .rd_left(rd_left),
    .n_wr(n_wr), .n_rd(n_rd), .none_left(none_left)
  );

  assign wr_lane = LIDX_W'(lane_for(32'(pkt_nw) + 32'(pkt_nr), 32'(idx)));
  assign rd_lane = LIDX_W'(lane_for(32'(pkt_nr), 32'(idx)));

  spi_seq_lanes #(.PKT_BYTES(PKT_BYTES), .LIDX_W(LIDX_W), .WORD_W(WORD_W)) u_lanes (
    .tx_word_q(tx_word), .wr_byte(wr_data), .wr_lane(wr_lane),
    .tx_word_nx(tx_word_nx), .rx_word(rx_word), .rd_lane(rd_lane),
    .rd_byte(rd_byte)
  );

  spi_seq_timer #(.LIMIT(TIMEOUT), .TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(ev_fire),
    .run((st == ST_WAIT) && !pkt_done), .expire(tmr_expire)
  );

  assign ev_accept     = (st == ST_IDLE) && txn_start;
  assign ev_plan_empty = (st == ST_PLAN) && none_left;
  assign ev_fire       = (st == ST_FIRE);
  assign ev_wr_take    = (st == ST_FILL) && wr_valid;
  assign ev_done_take  = (st == ST_WAIT) && pkt_done;
  assign ev_abort      = tmr_expire;
  assign ev_rd_take    = (st == ST_DRAIN) && rd_ready;
  assign ev_finish     = ev_plan_empty || ev_abort;
  assign wr_last       = (idx == pkt_nw - LANE_W'(1));
  assign rd_last       = (idx == pkt_nr - LANE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wr_left <= '0;
      rd_left <= '0;
      pkt_nw  <= '0;
      pkt_nr  <= '0;
      idx     <= '0;
      tx_word <= '0;
      rx_word <= '0;
      cs_q    <= 1'b0;
      clr_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      clr_q  <= ev_accept || ev_finish;
      done_q <= ev_finish;
      unique case (st)
        ST_IDLE: if (txn_start) begin
          wr_left <= txn_wr_cnt;
          rd_left <= txn_rd_cnt;
          cs_q    <= 1'b1;
          err_q   <= 1'b0;
          st      <= ST_PLAN;
        end
        ST_PLAN: if (none_left) begin
          cs_q <= 1'b0;
          st   <= ST_IDLE;
        end else begin
          pkt_nw  <= n_wr;
          pkt_nr  <= n_rd;
          wr_left <= wr_left - CNT_W'(n_wr);
          rd_left <= rd_left - CNT_W'(n_rd);
          idx     <= '0;
          tx_word <= '0;
          st      <= (n_wr != '0) ? ST_FILL : ST_FIRE;
        end
        ST_FILL: if (ev_wr_take) begin
          tx_word <= tx_word_nx;
          if (wr_last) begin
            idx <= '0;
            st  <= ST_FIRE;
          end else begin
            idx <= idx + LANE_W'(1);
          end
        end
        ST_FIRE: st <= ST_WAIT;
        ST_WAIT: if (ev_done_take) begin
          rx_word <= pkt_rx_word;
          idx     <= '0;
          st      <= (pkt_nr != '0) ? ST_DRAIN : ST_PLAN;
        end else if (ev_abort) begin
          cs_q  <= 1'b0;
          err_q <= 1'b1;
          st    <= ST_IDLE;
        end
        ST_DRAIN: if (ev_rd_take) begin
          if (rd_last) st <= ST_PLAN;
          else         idx <= idx + LANE_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pkt_start   = ev_fire;
  assign pkt_tx_word = tx_word;
  assign pkt_bits    = BITS_W'(bits_for(32'(pkt_nw) + 32'(pkt_nr)));
  assign wr_ready    = (st == ST_FILL);
  assign rd_valid    = (st == ST_DRAIN);
  assign rd_data     = rd_byte;
  assign cs_active   = cs_q;
  assign stat_clr    = clr_q;
  assign txn_done    = done_q;
  assign txn_err     = err_q;

endmodule

// File: rtl/spi_pkt_seq_chk.sv
module spi_pkt_seq_chk #(
  parameter int CNT_W  = 8,
  parameter int WORD_W = 32,
  parameter int BITS_W = 6,
  parameter int LANE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_start,
  input logic [BITS_W-1:0] pkt_bits,
  input logic              cs_active,
  input logic              stat_clr,
  input logic              txn_done,
  input logic              txn_err,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [7:0]        rd_data,
  input logic              ev_fire,
  input logic              ev_abort,
  input logic              ev_done_take,
  input logic [CNT_W-1:0]  wr_left,
  input logic [LANE_W-1:0] pkt_nr
);

  AST_PKT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (pkt_bits != '0) && (32'(pkt_bits) <= WORD_W) && (pkt_bits[2:0] == 3'd0)); // R1

  AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && (pkt_nr != '0)) |-> (wr_left == '0)); // R2

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_start, wr_ready, rd_valid})); // R2

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R5

  AST_CS_AT_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> cs_active); // R6

  AST_CS_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |-> !cs_active); // R6

  AST_CLR_AT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_active) |-> stat_clr); // R6

  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (txn_done && txn_err && !cs_active)); // R7

  AST_DONE_BEATS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done_take |-> !ev_abort); // R8

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txn_err) |-> txn_done); // R11

endmodule

bind spi_pkt_seq spi_pkt_seq_chk #(
  .CNT_W(CNT_W), .WORD_W(WORD_W), .BITS_W(BITS_W), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_bits(pkt_bits),
  .cs_active(cs_active), .stat_clr(stat_clr), .txn_done(txn_done),
  .txn_err(txn_err), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .ev_fire(ev_fire),
  .ev_abort(ev_abort), .ev_done_take(ev_done_take), .wr_left(wr_left),
  .pkt_nr(pkt_nr)
);

// File: tb/spi_pkt_seq_tb.sv
`timescale 1ns/1ps
module spi_pkt_seq_tb;

  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        txn_start;
  logic [7:0]  txn_wr_cnt, txn_rd_cnt;
  logic        txn_done, txn_err;
  logic        wr_valid, wr_ready, rd_valid, rd_ready;
  logic [7:0]  wr_data, rd_data;
  logic        pkt_start, pkt_done;
  logic [31:0] pkt_tx_word, pkt_rx_word;
  logic [5:0]  pkt_bits;
  logic        cs_active, stat_clr;

  always #4 clk = ~clk;

  spi_pkt_seq #(.CNT_W(8), .PKT_BYTES(4), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_wr_cnt(txn_wr_cnt),
    .txn_rd_cnt(txn_rd_cnt), .txn_done(txn_done), .txn_err(txn_err),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .pkt_start(pkt_start), .pkt_tx_word(pkt_tx_word), .pkt_bits(pkt_bits),
    .pkt_done(pkt_done), .pkt_rx_word(pkt_rx_word),
    .cs_active(cs_active), .stat_clr(stat_clr)
  );

  int checks = 0, fails = 0;
  logic [7:0]  wr_src [256];
  logic [7:0]  rd_got [256];
  logic [31:0] pk_tx  [64];
  int          pk_bits[64];
  int wptr = 0, rptr = 0, pcount = 0, resp_delay = 1, ncyc = 0;
  int cs_cyc = 0, clr_cyc = 0, done_cnt = 0, start_wo_cs = 0;
  bit wr_stall = 0, rd_stall = 0;

  task automatic check_eq(string tst, string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s %s: actual %0h expected %0h", req, tst, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rx_pattern(int p);
    return {8'(p + 16), 8'(p + 32), 8'(p + 48), 8'(p + 64)};
  endfunction

  // outgoing byte source
  initial begin
    bit hs = 0;
    wr_valid = 0; wr_data = 0;
    forever begin
      @(negedge clk);
      if (hs) wptr++;
      wr_valid = !(wr_stall && (ncyc % 3 == 0));
      wr_data  = wr_src[wptr % 256];
      hs       = wr_valid && wr_ready;
    end
  end

  // incoming byte sink
  initial begin
    rd_ready = 0;
    forever begin
      @(negedge clk);
      rd_ready = !(rd_stall && (ncyc % 2 == 0));
      if (rd_valid && rd_ready) begin
        rd_got[rptr % 256] = rd_data;
        rptr++;
      end
    end
  end

  // master model: answers resp_delay cycles after the start strobe, never if 0
  initial begin
    pkt_done = 0; pkt_rx_word = 0;
    forever begin
      @(negedge clk);
      if (pkt_start) begin
        int d;
        d = resp_delay;
        pk_tx[pcount % 64]   = pkt_tx_word;
        pk_bits[pcount % 64] = int'(pkt_bits);
        pcount++;
        if (d > 0) begin
          repeat (d) @(negedge clk);
          pkt_rx_word = rx_pattern(pcount - 1);
          pkt_done = 1;
          @(negedge clk);
          pkt_done = 0;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      ncyc++;
      if (cs_active) cs_cyc++;
      if (stat_clr) clr_cyc++;
      if (txn_done) done_cnt++;
      if (pkt_start && !cs_active) start_wo_cs++;
    end
  end

  task automatic run_txn(string tst, int wc, int rc, int delay, bit ws, bit rs,
                         bit poke, bit exp_err);
    int t, ew, er, wi, ri, np;
    logic [7:0] exp_rd [256];
    @(negedge clk);
    for (int i = 0; i < 256; i++) wr_src[i] = 8'(8'h80 + i * 7 + wc);
    wptr = 0; rptr = 0; pcount = 0; cs_cyc = 0; clr_cyc = 0; done_cnt = 0;
    start_wo_cs = 0; resp_delay = delay; wr_stall = ws; rd_stall = rs;
    txn_wr_cnt = 8'(wc); txn_rd_cnt = 8'(rc); txn_start = 1;
    @(negedge clk);
    txn_start = 0;
    t = 0;
    while (!txn_done && t < 3000) begin
      if (poke && t == 6) begin
        txn_start = 1; txn_wr_cnt = 8'd1; txn_rd_cnt = 8'd1;
      end else txn_start = 0;
      @(negedge clk);
      t++;
    end
    txn_start = 0;
    check_eq(tst, "R6", "done seen", longint'(txn_done), 1);
    check_eq(tst, exp_err ? "R7" : "R11", "err flag", longint'(txn_err), longint'(exp_err));
    ew = wc; er = rc; wi = 0; ri = 0; np = 0;
    while (1) begin
      int w, r;
      logic [31:0] e;
      w = (ew < 4) ? ew : 4;
      r = (er < 4 - w) ? er : 4 - w;
      if (w + r == 0 || (exp_err && np == 1)) break;
      e = 0;
      for (int i = 0; i < w; i++) e |= 32'(wr_src[wi + i]) << (8 * (w + r - 1 - i));
      for (int i = 0; i < r; i++) exp_rd[ri + i] = 8'(rx_pattern(np) >> (8 * (r - 1 - i)));
      if (np < pcount) begin
        check_eq(tst, "R1", $sformatf("bits of packet %0d", np), pk_bits[np], 8 * (w + r));
        check_eq(tst, "R4", $sformatf("tx word of packet %0d", np), pk_tx[np], e);
      end
      wi += w; ew -= w; er -= r; np++;
      if (!exp_err) ri += r;
    end
    check_eq(tst, "R2", "packet count", pcount, np);
    check_eq(tst, "R1", "writes consumed", wptr, wi);
    check_eq(tst, exp_err ? "R7" : "R5", "reads delivered", rptr, ri);
    for (int i = 0; i < ri && i < rptr; i++)
      check_eq(tst, "R5", $sformatf("read byte %0d", i), rd_got[i], exp_rd[i]);
    repeat (6) @(negedge clk);
    check_eq(tst, "R6", "cs released", longint'(cs_active), 0);
    check_eq(tst, "R6", "stat_clr cycles", clr_cyc, 2);
    check_eq(tst, "R6", "start without cs", start_wo_cs, 0);
    check_eq(tst, poke ? "R10" : "R6", "done pulses", done_cnt, 1);
  endtask

  task automatic t_reset();
    check_eq("reset", "R6", "cs_active", longint'(cs_active), 0);
    check_eq("reset", "R6", "stat_clr", longint'(stat_clr), 0);
    check_eq("reset", "R11", "done/err", longint'({txn_done, txn_err}), 0);
    check_eq("reset", "R1", "pkt_start", longint'(pkt_start), 0);
  endtask

  task automatic t_mixed();
    run_txn("mixed_6w5r", 6, 5, 2, 0, 0, 0, 0);
    check_eq("mixed_6w5r", "R3", "packet 0 bits", pk_bits[0], 32);
    check_eq("mixed_6w5r", "R3", "packet 1 bits", pk_bits[1], 32);
    check_eq("mixed_6w5r", "R3", "packet 2 bits", pk_bits[2], 24);
  endtask

  task automatic t_write_only();  run_txn("write_only_3", 3, 0, 1, 1, 0, 0, 0);  endtask
  task automatic t_read_only();   run_txn("read_only_9", 0, 9, 5, 0, 1, 0, 0);   endtask
  task automatic t_full_word();   run_txn("full_4w4r", 4, 4, 3, 1, 1, 0, 0);     endtask
  task automatic t_pair();        run_txn("pair_1w1r", 1, 1, 1, 0, 0, 0, 0);     endtask

  task automatic t_empty();
    run_txn("empty", 0, 0, 1, 0, 0, 0, 0);
    check_eq("empty", "R9", "cs cycles", cs_cyc, 1);
    check_eq("empty", "R9", "packets", pcount, 0);
  endtask

  task automatic t_timeout();
    run_txn("timeout", 6, 5, 0, 0, 0, 0, 1);
    check_eq("timeout", "R7", "packets before abort", pcount, 1);
  endtask

  task automatic t_edge();
    run_txn("edge_last_cycle", 2, 2, TMO, 0, 0, 0, 0);      // R8
    run_txn("edge_one_late", 2, 2, TMO + 1, 0, 0, 0, 1);    // R7
    run_txn("after_abort", 1, 2, 2, 0, 0, 0, 0);            // R11
  endtask

  task automatic t_busy_start();  run_txn("busy_start", 6, 5, 3, 0, 0, 1, 0);  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; txn_start = 0; txn_wr_cnt = 0; txn_rd_cnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_write_only();
    t_read_only();
    t_full_word();
    t_pair();
    t_empty();
    t_timeout();
    t_edge();
    t_busy_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule